// File: doc/BRIEF.md
# Extended Mode Register Update Sequencer

This block sits beside an SDRAM command scheduler. It rewrites the low-power extended mode register of the attached memory whenever a new setting for partial-array self refresh, temperature compensation or output drive strength is requested. The block takes the request, waits until no access is in flight, and then drives a fixed burst of commands: precharge all banks, a mode register set aimed at the extended register, and an auto-refresh. Because the sequence carries its own auto-refresh, the surrounding controller can count it as the refresh for that interval.

Each gap between commands comes from a cycle count programmed on an input: one count for precharge-to-mode-set, one for mode-set-to-next-command and one for refresh-to-activate. Every cycle in those gaps is a NOP. The busy output tells the scheduler to keep off the bus from the precharge until the refresh gap has run out.

Top module: `emr_update_seq`

## Requirements
- R1: After reset the command bus shows NOP, encoded as {cs_n,ras_n,cas_n,we_n} = 4'b0111, with bank address 0, row address 0 and busy low.
- R2: A sequence issues exactly three commands in this order: precharge-all (4'b0010), mode register set (4'b0000), auto-refresh (4'b0001).
- R3: During precharge-all, row address bit 10 is 1, every other row address bit is 0, and the bank address is 0.
- R4: During the mode register set the bank address is 2 and the row address holds partial-array self refresh in bits 2:0, temperature compensation in bits 4:3, drive strength in bits 6:5, and 0 above.
- R5: The mode register set comes exactly trp cycles after the precharge-all.
- R6: The auto-refresh comes exactly tmrd cycles after the mode register set.
- R7: Busy is high from the precharge-all cycle through the cycle trfc-1 after the auto-refresh, and is low exactly trfc cycles after it.
- R8: A request raised while access_busy is high is held; nothing is issued and busy stays low until access_busy is low, and the precharge-all appears in the cycle after the first clock edge that sees access_busy low. A request with access_busy low starts precharge-all in the cycle after the request edge.
- R9: Every cycle that is not one of the three commands, idle or waiting, drives NOP with bank address 0 and row address 0.
- R10: A delay count of 0 behaves as a count of 1.
- R11: The field values written are those present on the inputs at the request edge; later field changes are ignored. A request arriving while busy is high is held and starts its own sequence one idle cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req_i | input | 1 | One-cycle request to rewrite the extended register |
| pasr_i | input | 3 | New partial-array self refresh field |
| tcr_i | input | 2 | New temperature compensation field |
| ds_i | input | 2 | New drive strength field |
| access_busy_i | input | 1 | High while a normal access is in progress |
| trp_i | input | DLY_W | Precharge-to-mode-set gap in cycles, held stable during a sequence |
| tmrd_i | input | DLY_W | Mode-set-to-refresh gap in cycles, held stable during a sequence |
| trfc_i | input | DLY_W | Refresh-to-activate gap in cycles, held stable during a sequence |
| cmd_o | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Row address |
| busy_o | output | 1 | Sequence owns the command bus |

## Verification
The sequence runs with mid-sized gaps, with every gap at its minimum of one, with every gap programmed as zero and with long, unequal gaps. Together these separate an off-by-one in the wait counter from a wrong choice of count, and show whether the skip-the-wait path works. Further patterns hold access_busy high across a request, change the field inputs while a sequence runs, and raise a second request during busy. These show whether the start is gated correctly, whether the fields are captured at the right edge and whether a queued request is lost.

// File: rtl/emr_pkg.sv
package emr_pkg;

  // Command word {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_MRD,
    ST_REF,
    ST_WAIT_RFC
  } seq_st_e;

  // Packed so that the concatenation lands ds[6:5], tcr[4:3], pasr[2:0]
  typedef struct packed {
    logic [1:0] ds;
    logic [1:0] tcr;
    logic [2:0] pasr;
  } emr_fields_t;

  localparam int EMR_W = $bits(emr_fields_t);

endpackage

// File: rtl/emr_req_latch.sv
module emr_req_latch
  import emr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  emr_fields_t fields_i,
  input  logic        take_i,
  output logic        pend_o,
  output emr_fields_t fields_o
);

  logic        pend_q, pend_d;
  emr_fields_t fld_q, fld_d;

  always_comb begin
    pend_d = (pend_q | req_i) & ~take_i;
    fld_d  = req_i ? fields_i : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fld_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (req_i) fld_q <= fld_d;
    end
  end

  // A request in the current cycle is visible at once
  assign pend_o   = pend_q | req_i;
  assign fields_o = fld_d;

endmodule

// File: rtl/emr_delay_cnt.sv
module emr_delay_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             single_o,
  output logic             last_o
);

  logic [DLY_W-1:0] cnt_q, cnt_d, eff;

  always_comb begin
    eff      = (dly_i == '0) ? DLY_W'(1) : dly_i;
    single_o = (eff == DLY_W'(1));
    cnt_d    = cnt_q;
    if (load_i)     cnt_d = eff - DLY_W'(1);
    else if (dec_i) cnt_d = cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_i | dec_i) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == DLY_W'(1));

endmodule

// File: rtl/emr_cmd_encode.sv
module emr_cmd_encode
  import emr_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  seq_st_e          state_i,
  input  emr_fields_t      fields_i,
  output logic [3:0]       cmd_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);

  localparam int AP_BIT = 10;
  localparam int EMR_BA = 2;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (state_i)
      ST_PRE: begin
        cmd_o  = CMD_PRE;
        addr_o = ROW_W'(1) << AP_BIT;
      end
      ST_MRS: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(EMR_BA);
        addr_o = {{(ROW_W-EMR_W){1'b0}}, fields_i};
      end
      ST_REF:  cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/emr_update_seq.sv
module emr_update_seq
  import emr_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req_i,
  input  logic [2:0]       pasr_i,
  input  logic [1:0]       tcr_i,
  input  logic [1:0]       ds_i,
  input  logic             access_busy_i,
  input  logic [DLY_W-1:0] trp_i,
  input  logic [DLY_W-1:0] tmrd_i,
  input  logic [DLY_W-1:0] trfc_i,
  output logic [3:0]       cmd_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o
);

  seq_st_e          state_q, state_d;
  emr_fields_t      req_fields, act_q;
  logic             pend, start;
  logic             ld, dec, single, last;
  logic [DLY_W-1:0] dly_sel;

  emr_req_latch u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (upd_req_i),
    .fields_i ({ds_i, tcr_i, pasr_i}),
    .take_i   (start),
    .pend_o   (pend),
    .fields_o (req_fields)
  );

  emr_delay_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ld),
    .dec_i    (dec),
    .dly_i    (dly_sel),
    .single_o (single),
    .last_o   (last)
  );

  assign start = (state_q == ST_IDLE) & pend & ~access_busy_i;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    dec     = 1'b0;
    dly_sel = trp_i;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PRE;
      ST_PRE: begin
        dly_sel = trp_i;
        ld      = 1'b1;
        state_d = single ? ST_MRS : ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        dec = 1'b1;
        if (last) state_d = ST_MRS;
      end
      ST_MRS: begin
        dly_sel = tmrd_i;
        ld      = 1'b1;
        state_d = single ? ST_REF : ST_WAIT_MRD;
      end
      ST_WAIT_MRD: begin
        dec = 1'b1;
        if (last) state_d = ST_REF;
      end
      ST_REF: begin
        dly_sel = trfc_i;
        ld      = 1'b1;
        state_d = single ? ST_IDLE : ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        dec = 1'b1;
        if (last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) act_q <= req_fields;
    end
  end

  emr_cmd_encode #(.ROW_W(ROW_W), .BA_W(BA_W)) u_enc (
    .state_i  (state_q),
    .fields_i (act_q),
    .cmd_o    (cmd_o),
    .ba_o     (ba_o),
    .addr_o   (addr_o)
  );

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/emr_update_chk.sv
module emr_update_chk
  import emr_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             access_busy_i,
  input logic [3:0]       cmd_o,
  input logic [BA_W-1:0]  ba_o,
  input logic [ROW_W-1:0] addr_o,
  input logic             busy_o
);

  // Last non-NOP command seen; refresh stands for "sequence complete"
  logic [3:0] last_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_cmd_q <= CMD_REF;
    else if (cmd_o != CMD_NOP) last_cmd_q <= cmd_o;
  end

  p_pre_after_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> (last_cmd_q == CMD_REF));
  p_mrs_after_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (last_cmd_q == CMD_PRE));
  p_ref_after_mrs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |-> (last_cmd_q == CMD_MRS));
  p_pre_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> (addr_o == (ROW_W'(1) << 10)) && (ba_o == '0));
  p_mrs_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (ba_o == BA_W'(2)) && (addr_o[ROW_W-1:EMR_W] == '0));
  p_busy_cmds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> busy_o);
  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!$past(access_busy_i) && (cmd_o == CMD_PRE)));
  p_idle_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cmd_o == CMD_NOP) && (ba_o == '0) && (addr_o == '0));

endmodule

bind emr_update_seq emr_update_chk #(.ROW_W(ROW_W), .BA_W(BA_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .access_busy_i (access_busy_i),
  .cmd_o         (cmd_o),
  .ba_o          (ba_o),
  .addr_o        (addr_o),
  .busy_o        (busy_o)
);

// File: tb/test_emr_update_seq.sv
module test_emr_update_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int BA_W  = 2;
  localparam int DLY_W = 8;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             upd_req;
  logic [2:0]       pasr;
  logic [1:0]       tcr, ds;
  logic             access_busy;
  logic [DLY_W-1:0] trp, tmrd, trfc;
  logic [3:0]       cmd;
  logic [BA_W-1:0]  ba;
  logic [ROW_W-1:0] addr;
  logic             busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int              at;
    logic [3:0]      cmd;
    logic [1:0]      ba;
    logic [ROW_W-1:0] addr;
    logic            busy;
    string           tag;
  } exp_t;

  exp_t exp_q[$];

  emr_update_seq #(.ROW_W(ROW_W), .BA_W(BA_W), .DLY_W(DLY_W)) i_emr_update_seq (
    .clk(clk), .rst_n(rst_n), .upd_req_i(upd_req), .pasr_i(pasr), .tcr_i(tcr),
    .ds_i(ds), .access_busy_i(access_busy), .trp_i(trp), .tmrd_i(tmrd),
    .trfc_i(trfc), .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input logic [3:0] c, input logic [1:0] b,
                      input logic [ROW_W-1:0] a, input logic bz, input string tag);
    exp_t e;
    e.at = at; e.cmd = c; e.ba = b; e.addr = a; e.busy = bz; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // Expected cycles of one sequence starting with precharge at cycle s;
  // returns the cycle in which busy is low again.
  task automatic push_seq(input int s, input logic [6:0] f, input int rp,
                          input int mrd, input int rfc, output int fin);
    int m, r;
    m = s + eff(rp);
    r = m + eff(mrd);
    fin = r + eff(rfc);
    push(s, C_PRE, 2'd0, 13'h0400, 1'b1, "R2 R3");
    for (int t = s + 1; t < m; t++) push(t, C_NOP, 2'd0, '0, 1'b1, "R5 R9");
    push(m, C_MRS, 2'd2, {6'd0, f}, 1'b1, "R4 R5 R11");
    for (int t = m + 1; t < r; t++) push(t, C_NOP, 2'd0, '0, 1'b1, "R6 R9");
    push(r, C_REF, 2'd0, '0, 1'b1, "R2 R6");
    for (int t = r + 1; t < fin; t++) push(t, C_NOP, 2'd0, '0, 1'b1, "R7 R9");
    push(fin, C_NOP, 2'd0, '0, 1'b0, "R7 R10");
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (cmd !== e.cmd || ba !== e.ba || addr !== e.addr || busy !== e.busy) begin
        errors++;
        $display("FAIL %s cycle %0d: cmd=%b ba=%0d addr=%h busy=%b expected cmd=%b ba=%0d addr=%h busy=%b",
                 e.tag, cyc, cmd, ba, addr, busy, e.cmd, e.ba, e.addr, e.busy);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_dly(input int rp, input int mrd, input int rfc);
    trp = DLY_W'(rp); tmrd = DLY_W'(mrd); trfc = DLY_W'(rfc);
  endtask

  // Plain update with access_busy low; optionally scramble fields afterwards
  task automatic run(input logic [6:0] f, input int rp, input int mrd,
                     input int rfc, input bit scramble);
    int fin;
    @(negedge clk);
    set_dly(rp, mrd, rfc);
    {ds, tcr, pasr} = f;
    upd_req = 1'b1;
    push_seq(cyc + 1, f, rp, mrd, rfc, fin);
    @(negedge clk);
    upd_req = 1'b0;
    if (scramble) {ds, tcr, pasr} = ~f;
    drain();
  endtask

  initial begin
    int fin, s2, fin2;
    rst_n = 1'b0; upd_req = 1'b0; access_busy = 1'b0;
    pasr = '0; tcr = '0; ds = '0;
    set_dly(1, 1, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (cmd !== C_NOP || ba !== '0 || addr !== '0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1: cmd=%b ba=%0d addr=%h busy=%b expected cmd=0111 ba=0 addr=0000 busy=0",
               cmd, ba, addr, busy);
    end

    run(7'b10_01_101, 2, 2, 4, 1'b0);   // R2..R7 mid-sized gaps
    run(7'b01_10_011, 1, 1, 1, 1'b0);   // minimum gaps
    run(7'b11_11_111, 0, 0, 0, 1'b0);   // R10 zero counts
    run(7'b00_01_010, 5, 3, 7, 1'b1);   // long gaps, R11 fields changed mid-run

    // R8: request held while an access is in progress
    @(negedge clk);
    set_dly(2, 3, 2);
    access_busy = 1'b1;
    {ds, tcr, pasr} = 7'b01_00_110;
    upd_req = 1'b1;
    for (int t = cyc + 1; t <= cyc + 4; t++) push(t, C_NOP, 2'd0, '0, 1'b0, "R8");
    @(negedge clk);
    upd_req = 1'b0;
    {ds, tcr, pasr} = 7'b10_10_001;     // R11: ignored, latched value wins
    repeat (3) @(negedge clk);
    access_busy = 1'b0;
    push_seq(cyc + 1, 7'b01_00_110, 2, 3, 2, fin);
    drain();

    // R11: second request during busy runs one idle cycle after busy falls
    @(negedge clk);
    set_dly(2, 2, 3);
    {ds, tcr, pasr} = 7'b00_11_100;
    upd_req = 1'b1;
    push_seq(cyc + 1, 7'b00_11_100, 2, 2, 3, fin);
    @(negedge clk);
    upd_req = 1'b0;
    access_busy = 1'b1;                 // ignored while sequence runs
    @(negedge clk);
    access_busy = 1'b0;
    {ds, tcr, pasr} = 7'b11_01_001;
    upd_req = 1'b1;
    s2 = fin + 1;
    push_seq(s2, 7'b11_01_001, 2, 2, 3, fin2);
    @(negedge clk);
    upd_req = 1'b0;
    {ds, tcr, pasr} = 7'b00_00_000;
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule